// File: doc/BRIEF.md
# I2C Status Flag and Interrupt Controller

This block keeps the status flags of an I2C master peripheral together with its interrupt-enable mask. The transfer engine and the data buffer raise flags through one-cycle set pulses, and lower the data-ready and error flags through hardware clear pulses. Software reaches the block through a small register port with four locations: status, interrupt enable, interrupt vector and DMA control. The read data is combinational from the current state. Side effects of a register access take place at the clock edge on which the strobe is sampled.

One interrupt line is high while any flag that is also enabled is set. Two DMA request lines follow the receive-ready and transmit-ready flags, each only while its DMA enable is on. A read of the vector register gives the lowest pending enabled source and acknowledges that source in the same access. Turning on DMA for a direction also removes the interrupt enable of the matching ready flag, so the DMA engine and the interrupt handler never both serve the same flag.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset every flag, the interrupt-enable mask and both DMA enables are zero, and irq, dreq_rx and dreq_tx are low.
- R2: irq is high exactly when the status register and the enable mask share at least one set bit.
- R3: Address 0 reads the status register: bit 1 no-acknowledge, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 10 transmit underflow, bit 11 receive overrun and bit 15 start-byte detected. Bit 12 shows the bus_busy input, and all other bits read zero. A set pulse on flag_set for an implemented bit sets that flag.
- R4: A write to address 0 clears only the flags whose bit is set in both wdata and 16'h0027. The receive-ready, transmit-ready, underflow, overrun and start-byte flags are not changed by such a write.
- R5: A write to address 1 stores wdata[5:0] as the enable mask, and address 1 reads the mask back zero-extended.
- R6: A write to address 3 keeps only wdata bit 15 (receive DMA enable) and bit 7 (transmit DMA enable), and address 3 reads them back at those positions.
- R7: A write to address 3 with bit 15 set clears enable bit 3. A write with bit 7 set clears enable bit 4. The other enable bits are kept.
- R8: dreq_rx equals the receive-ready flag AND the receive DMA enable. dreq_tx equals the transmit-ready flag AND the transmit DMA enable.
- R9: Address 2 reads the index plus one of the lowest set bit of status AND mask, or 0 when none is set. A read with rd_en high clears that status bit.
- R10: With rd_en low, presenting address 2 has no side effect. A write to address 2 has no effect.
- R11: A set pulse on a flag in the same cycle as a software clear of that flag (status write or vector read) leaves the flag set.
- R12: A pulse on flag_clr clears the matching implemented flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 DMA control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, needed for the vector read side effect |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| bus_busy | input | 1 | Bus-busy level merged into status bit 12 |
| flag_set | input | 16 | Hardware set pulses, one per status bit |
| flag_clr | input | 16 | Hardware clear pulses, one per status bit |
| irq | output | 1 | Combined interrupt |
| dreq_rx | output | 1 | Receive DMA request |
| dreq_tx | output | 1 | Transmit DMA request |

## Verification
The bench targets the cases where a set pulse meets a software clear of the same flag. A design that gave the clear priority would drop an event and report the flag as zero. It also checks that a status write cannot clear receive-ready, transmit-ready or the error flags, which would silently discard data-ready state. The vector read is checked with several sources pending and with none pending. A wrong priority would acknowledge the wrong source, and a missing "+1" would make an empty result look like source zero. Address 2 is also presented without the read strobe, to catch a design that consumes a source on a mere address decode. The DMA writes are checked to remove exactly enable bits 3 and 4, because removing too much or too little leaves an interrupt raised alongside a DMA request.

// File: rtl/i2c_irq_status.sv
module i2c_irq_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        bus_busy,
  input  logic [15:0] flag_set,
  input  logic [15:0] flag_clr,
  output logic        irq,
  output logic        dreq_rx,
  output logic        dreq_tx
);
  localparam logic [1:0]  A_STAT = 2'd0;
  localparam logic [1:0]  A_IEN  = 2'd1;
  localparam logic [1:0]  A_VEC  = 2'd2;
  localparam logic [1:0]  A_DMA  = 2'd3;
  localparam logic [15:0] FLAGS  = 16'h8C1E;
  localparam logic [15:0] SW_CLR = 16'h0027;
  localparam int BUSY_BIT = 12;
  localparam int RXD_BIT  = 15;
  localparam int TXD_BIT  = 7;
  localparam int RRDY     = 3;
  localparam int XRDY     = 4;

  logic [15:0] stat_q, stat_d;
  logic [5:0]  ien_q, ien_d;
  logic        rxd_q, txd_q;
  logic [15:0] pend;
  logic [3:0]  vec_idx;
  logic        vec_hit;
  logic [4:0]  vec_val;

  wire wr_stat = wr_en && addr == A_STAT;
  wire wr_ien  = wr_en && addr == A_IEN;
  wire wr_dma  = wr_en && addr == A_DMA;
  wire rd_vec  = rd_en && addr == A_VEC;

  assign pend = stat_q & {10'd0, ien_q};

  always_comb begin
    vec_hit = 1'b0;
    vec_idx = '0;
    for (int i = 15; i >= 0; i--) begin
      if (pend[i]) begin
        vec_hit = 1'b1;
        vec_idx = 4'(i);
      end
    end
  end

  assign vec_val = vec_hit ? {1'b0, vec_idx} + 5'd1 : 5'd0;

  always_comb begin
    stat_d = stat_q & ~flag_clr;
    if (wr_stat) stat_d = stat_d & ~(wdata & SW_CLR);
    if (rd_vec && vec_hit) stat_d[vec_idx] = 1'b0;
    stat_d = (stat_d | flag_set) & FLAGS;
  end

  always_comb begin
    ien_d = ien_q;
    if (wr_ien) ien_d = wdata[5:0];
    else if (wr_dma) begin
      if (wdata[RXD_BIT]) ien_d[RRDY] = 1'b0;
      if (wdata[TXD_BIT]) ien_d[XRDY] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      rxd_q  <= 1'b0;
      txd_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
      if (wr_dma) begin
        rxd_q <= wdata[RXD_BIT];
        txd_q <= wdata[TXD_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: begin
        rdata = stat_q;
        rdata[BUSY_BIT] = bus_busy;
      end
      A_IEN:  rdata = {10'd0, ien_q};
      A_VEC:  rdata = {11'd0, vec_val};
      default: begin
        rdata[RXD_BIT] = rxd_q;
        rdata[TXD_BIT] = txd_q;
      end
    endcase
  end

  assign irq     = |pend;
  assign dreq_rx = stat_q[RRDY] & rxd_q;
  assign dreq_tx = stat_q[XRDY] & txd_q;
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] wdata,
  input logic [15:0] flag_set,
  input logic [15:0] flag_clr,
  input logic [15:0] stat_q,
  input logic [5:0]  ien_q,
  input logic        irq,
  input logic        dreq_rx,
  input logic        dreq_tx
);
  localparam logic [15:0] FLAGS = 16'h8C1E;

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_set & FLAGS) != 16'd0) |=> ((stat_q & $past(flag_set & FLAGS)) == $past(flag_set & FLAGS)));

  p_ien_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (ien_q == $past(wdata[5:0])));

  p_dma_rx_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[15]) |=> (!ien_q[3]));

  p_dma_tx_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[7]) |=> (!ien_q[4]));

  p_rrdy_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && stat_q[3] && !flag_clr[3]) |=> stat_q[3]);

  p_no_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en && flag_set == 16'd0 && flag_clr == 16'd0) |=> $stable(stat_q));

  p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wdata[15]) |=> !dreq_rx);

  p_tx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wdata[7]) |=> !dreq_tx);

  p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[5:0] == 6'd0) |=> !irq);
endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .flag_set(flag_set), .flag_clr(flag_clr),
  .stat_q(stat_q), .ien_q(ien_q), .irq(irq), .dreq_rx(dreq_rx), .dreq_tx(dreq_tx)
);

// File: tb/i2c_irq_status_bench.sv
`timescale 1ns/1ps
module i2c_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, bus_busy = 1'b0;
  logic [15:0] wdata = '0, flag_set = '0, flag_clr = '0;
  logic [15:0] rdata;
  logic irq, dreq_rx, dreq_tx;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] m_stat;
  logic [5:0]  m_ien;
  logic        m_rx, m_tx;

  always #5 clk = ~clk;

  i2c_irq_status u_i2c_irq_status (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .bus_busy(bus_busy), .flag_set(flag_set),
    .flag_clr(flag_clr), .irq(irq), .dreq_rx(dreq_rx), .dreq_tx(dreq_tx)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] lowest(logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 5'(i + 1);
    return 5'd0;
  endfunction

  function automatic logic [15:0] exp_read(logic [1:0] a, logic b);
    logic [15:0] r = '0;
    case (a)
      2'd0: begin r = m_stat; r[12] = b; end
      2'd1: r = {10'd0, m_ien};
      2'd2: r = {11'd0, lowest(m_stat & {10'd0, m_ien})};
      default: begin r[15] = m_rx; r[7] = m_tx; end
    endcase
    return r;
  endfunction

  task automatic step(input logic [1:0] a, input logic w, input logic r,
                      input logic [15:0] wd, input logic [15:0] fs,
                      input logic [15:0] fc, input logic b, output logic [15:0] seen);
    logic [15:0] nxt;
    logic [4:0] lw;
    addr = a; wr_en = w; rd_en = r; wdata = wd; flag_set = fs; flag_clr = fc; bus_busy = b;
    #1;
    seen = rdata;
    chk(a == 2'd0 ? "R3" : a == 2'd1 ? "R5" : a == 2'd2 ? "R9" : "R6", rdata, exp_read(a, b));
    chk("R2", 16'(irq), 16'((m_stat & {10'd0, m_ien}) != 0));
    chk("R8", {14'd0, dreq_rx, dreq_tx}, {14'd0, m_stat[3] & m_rx, m_stat[4] & m_tx});
    @(posedge clk);
    nxt = m_stat & ~fc;
    if (w && a == 2'd0) nxt = nxt & ~(wd & 16'h0027);
    lw = lowest(m_stat & {10'd0, m_ien});
    if (r && a == 2'd2 && lw != 0) nxt[lw - 1] = 1'b0;
    m_stat = (nxt | fs) & 16'h8C1E;
    if (w && a == 2'd1) m_ien = wd[5:0];
    else if (w && a == 2'd3) begin
      if (wd[15]) m_ien[3] = 1'b0;
      if (wd[7])  m_ien[4] = 1'b0;
    end
    if (w && a == 2'd3) begin m_rx = wd[15]; m_tx = wd[7]; end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    m_stat = '0; m_ien = '0; m_rx = 0; m_tx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {13'd0, irq, dreq_rx, dreq_tx}, 16'd0);
    step(2'd0, 0, 0, 0, 0, 0, 0, v); chk("R1", v, 16'h0000);
    step(2'd1, 0, 0, 0, 0, 0, 0, v); chk("R1", v, 16'h0000);
    step(2'd3, 0, 0, 0, 0, 0, 0, v); chk("R1", v, 16'h0000);
    // R11: set and software clear of NACK together
    step(2'd0, 1, 0, 16'h0002, 16'h0002, 0, 0, v);
    step(2'd0, 0, 0, 0, 0, 0, 0, v); chk("R11", v, 16'h0002);
    // R4: status write cannot clear ready or error flags
    step(2'd0, 0, 0, 0, 16'h8C18, 0, 0, v);
    step(2'd0, 1, 0, 16'hFFFF, 0, 0, 0, v);
    step(2'd0, 0, 0, 0, 0, 0, 0, v); chk("R4", v, 16'h8C18);
    // R12: hardware clear
    step(2'd0, 0, 0, 0, 0, 16'hFFFF, 0, v);
    step(2'd0, 0, 0, 0, 0, 0, 0, v); chk("R12", v, 16'h0000);
    step(2'd0, 0, 0, 0, 0, 0, 1, v); chk("R3", v, 16'h1000);
    // R5 and R7
    step(2'd1, 1, 0, 16'hFFFF, 0, 0, 0, v);
    step(2'd1, 0, 0, 0, 0, 0, 0, v); chk("R5", v, 16'h003F);
    step(2'd3, 1, 0, 16'hFFFF, 0, 0, 0, v);
    step(2'd1, 0, 0, 0, 0, 0, 0, v); chk("R7", v, 16'h0027);
    step(2'd3, 0, 0, 0, 0, 0, 0, v); chk("R6", v, 16'h8080);
    // R8
    step(2'd0, 0, 0, 0, 16'h0018, 0, 0, v);
    chk("R8", {14'd0, dreq_rx, dreq_tx}, 16'h0003);
    step(2'd3, 1, 0, 16'h0000, 0, 0, 0, v);
    chk("R8", {14'd0, dreq_rx, dreq_tx}, 16'h0000);
    // R9: lowest first, then empty
    step(2'd1, 1, 0, 16'h003F, 16'h0002, 0, 0, v);
    chk("R2", 16'(irq), 16'h0001);
    step(2'd2, 0, 1, 0, 0, 0, 0, v); chk("R9", v, 16'h0002);
    step(2'd2, 0, 1, 0, 0, 0, 0, v); chk("R9", v, 16'h0004);
    step(2'd2, 0, 1, 0, 0, 0, 0, v); chk("R9", v, 16'h0005);
    step(2'd2, 0, 1, 0, 0, 0, 0, v); chk("R9", v, 16'h0000);
    // R10: no strobe, and a write to the vector register
    step(2'd0, 0, 0, 0, 16'h0002, 0, 0, v);
    step(2'd2, 0, 0, 0, 0, 0, 0, v); chk("R10", v, 16'h0002);
    step(2'd2, 1, 0, 16'hFFFF, 0, 0, 0, v);
    step(2'd0, 0, 0, 0, 0, 0, 0, v); chk("R10", v, 16'h0002);
    // R11: vector read acknowledging NACK while NACK is set again
    step(2'd2, 0, 1, 0, 16'h0002, 0, 0, v); chk("R11", v, 16'h0002);
    step(2'd0, 0, 0, 0, 0, 0, 0, v); chk("R11", v, 16'h0002);
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 4;
      step(2'($urandom), op == 1, op >= 2, 16'($urandom),
           16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom & $urandom),
           1'($urandom), v);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule